// File: doc/BRIEF.md
# LED Driver Control Register Target with Attention Line

This block is the control-plane end of a flash LED driver. A host processor reaches it over a two-wire I2C bus. The block answers as a target at one of four 7-bit addresses, picked by a two-bit board strap, and it owns a small file of four byte-wide registers. Three registers are written by the host: a command byte, a dimming byte and an auxiliary byte. Their contents go straight to the analog and power logic next door. The fourth register is a read-only status byte. It gathers event pulses from the protection circuits.

A transfer begins with a pointer byte. Every data byte after it, in either direction, moves the pointer on by one. The host can therefore stream through consecutive registers without sending the addresses again. A read first loads the pointer, then issues a repeated START with the read bit set.

When status events are latched, an active-low attention output tells the host to fetch the status byte. The host does not have to poll. Fetching that byte hands over the pending bits and releases the line. While an undervoltage flag is raised, the target acknowledges nothing.

Both bus lines are oversampled on the system clock, which must run at least eight times faster than SCL. The data line is modelled as a sampled input plus an output enable that pulls it low.

Top module: `i2c_attn_regfile`

## Requirements
- R1: The target acknowledges only the address byte whose upper seven bits equal binary 01100 followed by `strap_i[1:0]`. Strap 00 means tied to ground, 01 supply, 10 data line and 11 clock line. Any other address gets no ACK and is ignored until the next START.
- R2: A write consists of START, the address byte with bit 0 = 0, a pointer byte and one or more data bytes, then STOP. The target ACKs every byte by pulling SDA low in the ninth clock, and it stores each data byte at the current pointer.
- R3: The pointer is the pointer byte modulo 4. It increments by one after every data byte written or read and wraps from 3 to 0. It persists across transactions.
- R4: After a repeated START with address bit 0 = 1, the target sends the register at the pointer MSB first. It sends the next register after each master ACK and stops driving after a master NACK.
- R5: Index 0 is the command register (`cmd_o`), 1 the dimming register (`dim_o`) and 2 the auxiliary register (`aux_o`). All three are read/write and reset to 0. Index 3 is status: a write to it is acknowledged and has no effect.
- R6: Each `evt_i` bit that is high in a cycle sets the matching status bit. Status bits stay set until a read of index 3 delivers them; delivery clears exactly the bits sent. An event arriving in the clearing cycle is kept.
- R7: `attn_n_o` goes low when any event is latched. Only a read of index 3 releases it, and only if no undelivered status bits remain. Reading other registers leaves it low.
- R8: While `uv_i` is high, the target ACKs no byte. A byte that finishes while `uv_i` is high is discarded, and the target idles until the next START.
- R9: `sda_oe_o` changes only while the synchronized SCL is low.
- R10: A START or STOP in the middle of a byte abandons that byte without writing it. A START restarts address reception.
- R11: After reset, the three writable registers read 0, status is 0, `attn_n_o` is 1 and `sda_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| strap_i | input | 2 | Board strap giving the two low address bits |
| uv_i | input | 1 | Supply undervoltage flag; suppresses all ACKs |
| evt_i | input | 8 | Status event pulses, one per status bit |
| attn_n_o | output | 1 | Active-low attention request |
| cmd_o | output | 8 | Command register contents |
| dim_o | output | 8 | Dimming register contents |
| aux_o | output | 8 | Auxiliary register contents |

## Verification
The assertions watch four behaviours on every cycle:
- the data-line enable never moves while the synchronized clock is high;
- status bits and the attention line change only through events or a status delivery;
- no register write retires while undervoltage was flagged;
- the command byte changes only after a write strobe for index 0.

Some behaviours can only be shown by the bench's bus scenarios, because they depend on the whole byte sequence on the wire:
- which of the four strapped addresses is acknowledged;
- pointer wrap across both reads and writes;
- byte contents returned after a repeated START;
- the discarding of a byte cut short by START or STOP.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [4:0] DEV_ADDR_HI = 5'b01100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } eng_state_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_PTR,
        K_DATA
    } byte_kind_e;

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [STAGES:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int k = 1; k <= STAGES; k++) begin
            pipe_d[k] = pipe_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    // last synchronizer stage is the level, the extra stage is its history
    assign dout = pipe_q[STAGES-1];
    assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall = ~pipe_q[STAGES-1] & pipe_q[STAGES];

endmodule

// File: rtl/i2ct_regbank.sv
module i2ct_regbank
    import i2ct_pkg::*;
#(
    parameter int NREG = 4,
    localparam int PW  = $clog2(NREG),
    localparam int NRW = NREG - 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [PW-1:0]               wr_idx,
    input  logic [BYTE_W-1:0]           wr_data,
    input  logic [PW-1:0]               rd_idx,
    output logic [BYTE_W-1:0]           rd_data,
    input  logic                        stat_take,
    input  logic [BYTE_W-1:0]           stat_mask,
    input  logic [BYTE_W-1:0]           evt_i,
    output logic [BYTE_W-1:0]           status_o,
    output logic                        attn_o,
    output logic [NRW-1:0][BYTE_W-1:0]  rw_o
);

    typedef struct packed {
        logic [NRW-1:0][BYTE_W-1:0] rw;
        logic [BYTE_W-1:0]          stat;
        logic                       attn;
    } bank_t;

    bank_t q, d;
    logic [NRW-1:0]    wr_hit;
    logic [BYTE_W-1:0] all_regs [NREG];
    logic [BYTE_W-1:0] keep_mask;

    for (genvar i = 0; i < NRW; i++) begin : g_rw
        assign wr_hit[i]   = wr_en && (wr_idx == PW'(i));
        assign all_regs[i] = q.rw[i];
    end
    assign all_regs[NREG-1] = q.stat;

    assign keep_mask = stat_take ? ~stat_mask : '1;

    always_comb begin
        d = q;
        for (int i = 0; i < NRW; i++) begin
            if (wr_hit[i]) d.rw[i] = wr_data;
        end
        // delivered bits clear, fresh events always win
        d.stat = (q.stat & keep_mask) | evt_i;
        if (stat_take) d.attn = (|(q.stat & keep_mask)) | (|evt_i);
        else           d.attn = q.attn | (|evt_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data  = all_regs[rd_idx];
    assign status_o = q.stat;
    assign attn_o   = q.attn;
    assign rw_o     = q.rw;

endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
    import i2ct_pkg::*;
#(
    parameter int NREG = 4,
    localparam int PW  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic [6:0]        dev_addr,
    input  logic              uv_i,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [PW-1:0]     ptr_o,
    output logic              wr_en_o,
    output logic [PW-1:0]     wr_idx_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              take_o,
    output logic [PW-1:0]     take_idx_o,
    output logic [BYTE_W-1:0] tx_byte_o,
    output logic              sda_oe_o
);

    typedef struct packed {
        eng_state_e        state;
        byte_kind_e        kind;
        logic [BYTE_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              full;
        logic              rw;
        logic              mack;
        logic [PW-1:0]     ptr;
        logic              sda_oe;
        logic              wr_en;
        logic [PW-1:0]     wr_idx;
        logic [BYTE_W-1:0] wr_data;
        logic              take;
        logic [PW-1:0]     take_idx;
    } eng_t;

    eng_t q, d;
    logic start_c, stop_c, last_bit;

    assign start_c  = scl_s && sda_fall;
    assign stop_c   = scl_s && sda_rise;
    assign last_bit = (q.cnt == CNT_W'(BYTE_W - 1));

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        d.take  = 1'b0;
        if (start_c) begin
            d.state  = ST_RX;
            d.kind   = K_DEV;
            d.cnt    = '0;
            d.full   = 1'b0;
            d.sda_oe = 1'b0;
        end else if (stop_c) begin
            d.state  = ST_IDLE;
            d.full   = 1'b0;
            d.sda_oe = 1'b0;
        end else begin
            case (q.state)
                ST_RX: begin
                    if (scl_rise && !q.full) begin
                        d.shreg = {q.shreg[BYTE_W-2:0], sda_s};
                        d.cnt   = q.cnt + CNT_W'(1);
                        d.full  = last_bit;
                    end else if (scl_fall && q.full) begin
                        d.full = 1'b0;
                        d.cnt  = '0;
                        if (uv_i) begin
                            d.state = ST_IDLE;
                        end else begin
                            case (q.kind)
                                K_DEV: begin
                                    if (q.shreg[BYTE_W-1:1] == dev_addr) begin
                                        d.state  = ST_ACK;
                                        d.sda_oe = 1'b1;
                                        d.rw     = q.shreg[0];
                                    end else begin
                                        d.state = ST_IDLE;
                                    end
                                end
                                K_PTR: begin
                                    d.ptr    = q.shreg[PW-1:0];
                                    d.state  = ST_ACK;
                                    d.sda_oe = 1'b1;
                                end
                                default: begin
                                    d.wr_en   = 1'b1;
                                    d.wr_idx  = q.ptr;
                                    d.wr_data = q.shreg;
                                    d.ptr     = q.ptr + PW'(1);
                                    d.state   = ST_ACK;
                                    d.sda_oe  = 1'b1;
                                end
                            endcase
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (q.kind == K_DEV && q.rw) begin
                            d.state    = ST_TX;
                            d.cnt      = '0;
                            d.shreg    = rd_data;
                            d.sda_oe   = ~rd_data[BYTE_W-1];
                            d.take     = 1'b1;
                            d.take_idx = q.ptr;
                            d.ptr      = q.ptr + PW'(1);
                        end else begin
                            d.sda_oe = 1'b0;
                            d.state  = ST_RX;
                            d.kind   = (q.kind == K_DEV) ? K_PTR : K_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (last_bit) begin
                            d.sda_oe = 1'b0;
                            d.mack   = 1'b0;
                            d.state  = ST_MACK;
                        end else begin
                            d.cnt    = q.cnt + CNT_W'(1);
                            d.shreg  = {q.shreg[BYTE_W-2:0], 1'b0};
                            d.sda_oe = ~q.shreg[BYTE_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.state    = ST_TX;
                            d.cnt      = '0;
                            d.shreg    = rd_data;
                            d.sda_oe   = ~rd_data[BYTE_W-1];
                            d.take     = 1'b1;
                            d.take_idx = q.ptr;
                            d.ptr      = q.ptr + PW'(1);
                        end else begin
                            d.state = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.kind  <= K_DEV;
        end else begin
            q <= d;
        end
    end

    assign ptr_o      = q.ptr;
    assign wr_en_o    = q.wr_en;
    assign wr_idx_o   = q.wr_idx;
    assign wr_data_o  = q.wr_data;
    assign take_o     = q.take;
    assign take_idx_o = q.take_idx;
    assign tx_byte_o  = q.shreg;
    assign sda_oe_o   = q.sda_oe;

endmodule

// File: rtl/i2c_attn_regfile.sv
module i2c_attn_regfile
    import i2ct_pkg::*;
#(
    parameter int         NREG        = 4,
    parameter logic [4:0] ADDR_HI     = DEV_ADDR_HI,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [1:0] strap_i,
    input  logic       uv_i,
    input  logic [7:0] evt_i,
    output logic       attn_n_o,
    output logic [7:0] cmd_o,
    output logic [7:0] dim_o,
    output logic [7:0] aux_o
);

    localparam int PW  = $clog2(NREG);
    localparam int NRW = NREG - 1;

    logic [1:0] line_lvl, line_rise, line_fall;
    logic       scl_s;
    logic [PW-1:0]     ptr, wr_idx, take_idx;
    logic              wr_en, take, stat_take, attn;
    logic [BYTE_W-1:0] wr_data, rd_data, tx_byte, status_w;
    logic [NRW-1:0][BYTE_W-1:0] rw_regs;

    i2ct_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout (line_lvl),
        .rise (line_rise),
        .fall (line_fall)
    );

    assign scl_s = line_lvl[1];

    i2ct_engine #(.NREG(NREG)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .scl_rise  (line_rise[1]),
        .scl_fall  (line_fall[1]),
        .sda_s     (line_lvl[0]),
        .sda_rise  (line_rise[0]),
        .sda_fall  (line_fall[0]),
        .dev_addr  ({ADDR_HI, strap_i}),
        .uv_i      (uv_i),
        .rd_data   (rd_data),
        .ptr_o     (ptr),
        .wr_en_o   (wr_en),
        .wr_idx_o  (wr_idx),
        .wr_data_o (wr_data),
        .take_o    (take),
        .take_idx_o(take_idx),
        .tx_byte_o (tx_byte),
        .sda_oe_o  (sda_oe_o)
    );

    assign stat_take = take && (take_idx == PW'(NREG - 1));

    i2ct_regbank #(.NREG(NREG)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (ptr),
        .rd_data  (rd_data),
        .stat_take(stat_take),
        .stat_mask(tx_byte),
        .evt_i    (evt_i),
        .status_o (status_w),
        .attn_o   (attn),
        .rw_o     (rw_regs)
    );

    assign attn_n_o = ~attn;
    assign cmd_o    = rw_regs[0];
    assign dim_o    = rw_regs[1];
    assign aux_o    = rw_regs[2];

endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk #(
    parameter int NREG = 4,
    localparam int PW  = $clog2(NREG)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_s,
    input logic          sda_oe,
    input logic          uv_i,
    input logic [7:0]    evt_i,
    input logic          attn_n,
    input logic [7:0]    status,
    input logic          stat_take,
    input logic          wr_en,
    input logic [PW-1:0] wr_idx,
    input logic [7:0]    cmd
);

    // R9
    sda_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(!scl_s));

    // R6
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(status) & ~status)) |-> $past(stat_take));

    // R7
    attn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(attn_n) |-> $past(|evt_i));

    // R7
    attn_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(attn_n) |-> $past(stat_take));

    // R8
    uv_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(!uv_i));

    // R5
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd) |-> $past(wr_en && wr_idx == PW'(0)));

endmodule

bind i2c_attn_regfile i2ct_chk #(.NREG(NREG)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe_o),
    .uv_i     (uv_i),
    .evt_i    (evt_i),
    .attn_n   (attn_n_o),
    .status   (status_w),
    .stat_take(stat_take),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .cmd      (cmd_o)
);

// File: tb/tb_i2c_attn_regfile.sv
module tb_i2c_attn_regfile;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic       sda_line;
    logic [1:0] strap = 2'b10;
    logic       uv = 1'b0;
    logic [7:0] evt = 8'h00;
    logic       attn_n;
    logic [7:0] cmd, dim, aux;

    int n_chk = 0;
    int n_bad = 0;
    int r9_viol = 0;
    logic prev_oe = 1'b0;
    bit done = 1'b0;

    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];
    logic [7:0] exp_reg [4];

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_attn_regfile dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_m),
        .sda_i   (sda_line),
        .sda_oe_o(sda_oe),
        .strap_i (strap),
        .uv_i    (uv),
        .evt_i   (evt),
        .attn_n_o(attn_n),
        .cmd_o   (cmd),
        .dim_o   (dim),
        .aux_o   (aux)
    );

    // R9 monitor: the pull-down must never move while the master holds SCL high
    always @(posedge clk) begin
        if (rst_n && (sda_oe !== prev_oe) && scl_m) r9_viol <= r9_viol + 1;
        prev_oe <= sda_oe;
    end

    task automatic chk(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic qwait();
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait(); qwait();
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            sda_m = b[i]; qwait();
            scl_m = 1'b1; qwait(); qwait();
            scl_m = 1'b0; qwait();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        ack = !sda_line; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            qwait();
            scl_m = 1'b1; qwait();
            b = {b[6:0], sda_line}; qwait();
            scl_m = 1'b0;
        end
        qwait();
        sda_m = !give_ack; qwait();
        scl_m = 1'b1; qwait(); qwait();
        scl_m = 1'b0; qwait();
        sda_m = 1'b1;
    endtask

    function automatic logic [6:0] dev_addr();
        return {5'b01100, strap};
    endfunction

    task automatic write_seq(input logic [7:0] ptr, input int n, output bit all_ack);
        bit a;
        bus_start();
        send_byte({dev_addr(), 1'b0}, a); all_ack = a;
        send_byte(ptr, a); all_ack &= a;
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], a); all_ack &= a;
        end
        bus_stop();
    endtask

    task automatic read_seq(input logic [7:0] ptr, input int n);
        bit a;
        bus_start();
        send_byte({dev_addr(), 1'b0}, a);
        send_byte(ptr, a);
        bus_start();
        send_byte({dev_addr(), 1'b1}, a);
        for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
        bus_stop();
    endtask

    task automatic read_cur(input int n);
        bit a;
        bus_start();
        send_byte({dev_addr(), 1'b1}, a);
        for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
        bus_stop();
    endtask

    task automatic pulse_evt(input logic [7:0] v);
        @(negedge clk); evt = v;
        @(negedge clk); evt = 8'h00;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        bit ok;
        bit a;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R11 reset state at the ports
        chk("R11 cmd", cmd, 0);
        chk("R11 dim", dim, 0);
        chk("R11 aux", aux, 0);
        chk("R11 attn_n", attn_n, 1);
        chk("R11 sda_oe", sda_oe, 0);
        for (int i = 0; i < 4; i++) exp_reg[i] = 8'h00;
        read_seq(8'h03, 1);
        chk("R11 status", rbuf[0], 0);

        // R1 sweep: every strap against every candidate address
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            for (int c = 0; c < 5; c++) begin
                logic [6:0] cand;
                cand = (c == 4) ? 7'h70 + 7'(s) : 7'h30 + 7'(c);
                bus_start();
                send_byte({cand, 1'b0}, a);
                bus_stop();
                chk("R1 addr ack", a, (cand == (7'h30 + 7'(s))) ? 1 : 0);
            end
        end
        strap = 2'b10;

        // R2 R3 R5 sweep: start pointer x burst length
        for (int p = 0; p < 4; p++) begin
            for (int n = 1; n <= 4; n++) begin
                for (int k = 0; k < n; k++) begin
                    wbuf[k] = 8'((p * 61 + n * 23 + k * 17 + 9) & 8'hFF);
                    if (((p + k) % 4) != 3) exp_reg[(p + k) % 4] = wbuf[k];
                end
                write_seq(8'(p), n, ok);
                chk("R2 burst acked", ok, 1);
                chk("R5 cmd port", cmd, exp_reg[0]);
                read_seq(8'((p + 1) % 4), 4);
                for (int k = 0; k < 4; k++)
                    chk("R3 R4 readback wrap", rbuf[k], exp_reg[(p + 1 + k) % 4]);
            end
        end

        // R3 pointer byte above 3 is taken modulo 4
        wbuf[0] = 8'hC3;
        write_seq(8'h05, 1, ok);
        exp_reg[1] = 8'hC3;
        chk("R3 ptr modulo dim", dim, 8'hC3);

        // R4 pointer carries into a read with no pointer byte
        read_seq(8'h00, 1);
        chk("R4 single read", rbuf[0], exp_reg[0]);
        read_cur(2);
        chk("R4 continued read", rbuf[0], exp_reg[1]);
        chk("R3 continued read wrap", rbuf[1], exp_reg[2]);

        // R6 R7 status events and attention
        pulse_evt(8'h05);
        chk("R7 attn asserted", attn_n, 0);
        read_seq(8'h01, 1);
        chk("R7 other read keeps attn", attn_n, 0);
        read_seq(8'h03, 1);
        chk("R6 status delivered", rbuf[0], 8'h05);
        chk("R7 attn released", attn_n, 1);
        read_seq(8'h03, 1);
        chk("R6 status cleared", rbuf[0], 8'h00);
        pulse_evt(8'h10);
        pulse_evt(8'h03);
        wbuf[0] = 8'hFF;
        write_seq(8'h03, 1, ok);
        chk("R5 status write acked", ok, 1);
        read_seq(8'h03, 1);
        chk("R6 sticky or", rbuf[0], 8'h13);
        chk("R7 attn after read", attn_n, 1);

        // R8 undervoltage
        uv = 1'b1;
        bus_start();
        send_byte({dev_addr(), 1'b0}, a);
        bus_stop();
        chk("R8 addr nack under uv", a, 0);
        uv = 1'b0;
        bus_start();
        send_byte({dev_addr(), 1'b0}, a);
        send_byte(8'h00, a);
        uv = 1'b1;
        send_byte(8'hAA, a);
        chk("R8 data nack under uv", a, 0);
        uv = 1'b0;
        send_byte(8'h55, a);
        chk("R8 idle after uv", a, 0);
        bus_stop();
        chk("R8 cmd kept", cmd, exp_reg[0]);

        // R10 STOP mid byte
        bus_start();
        send_byte({dev_addr(), 1'b0}, a);
        send_byte(8'h01, a);
        send_bits(8'h0F, 4);
        bus_stop();
        chk("R10 stop abort dim", dim, exp_reg[1]);

        // R10 START mid byte restarts addressing
        bus_start();
        send_byte({dev_addr(), 1'b0}, a);
        send_byte(8'h02, a);
        send_bits(8'hFF, 3);
        bus_start();
        send_byte({dev_addr(), 1'b0}, a);
        chk("R10 restart addr ack", a, 1);
        send_byte(8'h02, a);
        send_byte(8'h5A, a);
        bus_stop();
        chk("R10 restart write aux", aux, 8'h5A);

        chk("R9 oe quiet while scl high", r9_viol, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule